// File: doc/BRIEF.md
# Reset and Isolation Gasket Controller

This block decides when a large hard-macro accelerator is held in reset and when it is cut off from the surrounding fabric. Four things can hold the macro in reset: an active-low external reset pin, a flag raised while the programmable fabric is being configured, the isolation bit of a small control register, and the reset bit of that register. The two pin-level sources are asynchronous. They assert the macro reset at once and are released through a two-flop synchronizer. Every reset episode is then stretched so that it lasts a minimum number of reference-clock cycles. The reference clock is the slowest clock the macro receives, and the whole block runs on it.

Host accesses to the macro pass through a valid/ready channel that is closed while the macro is in reset. The block counts outstanding transactions on each bus that faces the macro. Software can therefore shut the macro down in order: wait for the buses to go idle, pulse the external reset, clear the reset bit, then clear the isolation bit. Once the macro is isolated, held in reset and idle, the block raises a power-down request for the supply switch.

Top module: `rst_gasket_ctrl`

## Requirements
- R1: `macro_rst` is high whenever any of these holds: `ext_rst_n` is low, `cfg_busy` is high, control bit 0 is 0 (isolation), or control bit 1 is 0 (reset). An asynchronous source asserts it with no clock edge needed.
- R2: Once a reset episode starts, `macro_rst` stays high for at least MIN_CYC (default 2) reference-clock cycles. When the last asynchronous source is released, `macro_rst` stays high after the 1st and 2nd rising edges and falls after the 3rd.
- R3: A write (`ctl_we`=1) stores `ctl_wdata[1:0]` into the control register, and `ctl_rdata` returns the stored value. Bit 1 = 0 asserts macro reset. Bit 0 = 0 enables isolation, and `iso_en` is the inverse of bit 0.
- R4: After `rst_n` the control register holds 2'b00, so `iso_en`=1 and `macro_rst`=1.
- R5: Host-to-macro channel. `mac_acc_valid` = `host_acc_valid` and `host_acc_ready` = `mac_acc_ready` while `macro_ready` is 1. Both are 0 while `macro_ready` is 0. `mac_acc_data` always equals `host_acc_data`. A source that sees `host_acc_ready` low must hold its request, because nothing is accepted while the macro is in reset.
- R6: Each bus has a counter that goes up on `bus_req_fire[i]` and down on `bus_rsp_fire[i]`. If both fire in the same cycle the count does not change. A response at a count of zero is ignored. `bus_idle` is 1 exactly when every counter is zero.
- R7: `pwr_down_req` rises one cycle after `iso_en`, `macro_rst` and `bus_idle` are all high together. It then holds until control bit 0 is written to 1, and it drops in the same cycle that write takes effect.
- R8: `macro_ready` is the inverse of `macro_rst`. It is 1 only when no source is active and the stretch count has run out.
- R9: Writing 2'b11 while the macro is already running does not reset it: `macro_rst` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (slowest macro clock) |
| rst_n | input | 1 | Controller reset, active low, async |
| ext_rst_n | input | 1 | External macro reset pin, active low, async |
| cfg_busy | input | 1 | Fabric configuration in progress, async |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Write data: bit1 run (0=reset), bit0 connect (0=isolate) |
| ctl_rdata | output | 2 | Control register readback |
| bus_req_fire | input | NBUS | Address handshake seen, per bus |
| bus_rsp_fire | input | NBUS | Response handshake seen, per bus |
| host_acc_valid | input | 1 | Host access request valid |
| host_acc_ready | output | 1 | Host access accepted |
| host_acc_data | input | DW | Host access payload |
| mac_acc_valid | output | 1 | Request valid toward macro |
| mac_acc_ready | input | 1 | Macro ready for request |
| mac_acc_data | output | DW | Payload toward macro |
| macro_rst | output | 1 | Reset to macro, active high |
| iso_en | output | 1 | Isolation enable to gasket |
| macro_ready | output | 1 | Macro accessible status |
| bus_idle | output | 1 | No outstanding transactions |
| pwr_down_req | output | 1 | Supply power-down request |

## Verification
The checker watches several rules on every cycle. An external reset pin that is low always shows up on `macro_rst`. A rising reset is never one cycle wide. No request reaches the macro while it is in reset. A power-down request never appears without isolation. An idle bus with no new requests stays idle. Register write effects are also checked one cycle after each write. Some behaviour only the bench scenarios can show. These are the exact release timing after a short asynchronous glitch, the counting up and down of outstanding transactions, the power-down request held back by a busy bus, and a same-value rewrite leaving the running macro alone.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  // Control register bit positions; software depends on them
  localparam int unsigned CTL_W       = 2;
  localparam int unsigned CTL_CONN_B  = 0;  // 0 = isolated
  localparam int unsigned CTL_RUN_B   = 1;  // 0 = held in reset

  typedef logic [CTL_W-1:0] ctl_t;

  localparam ctl_t CTL_RESET_VAL = '0;
endpackage

// File: rtl/rgc_rst_sync.sv
module rgc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst,     // active-high asynchronous request
  output logic sync_act  // released synchronously
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain_q <= '1;
    else      chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign sync_act = chain_q[STAGES-1];
endmodule

// File: rtl/rgc_stretch.sv
module rgc_stretch #(
  parameter int unsigned MIN_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  output logic active
);
  localparam int unsigned HOLD = MIN_CYC - 1;
  localparam int unsigned CW   = (MIN_CYC < 2) ? 1 : $clog2(MIN_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= CW'(HOLD);
    else if (src)            cnt_q <= CW'(HOLD);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active = src | (cnt_q != '0);
endmodule

// File: rtl/rgc_txn_cnt.sv
module rgc_txn_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic zero
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/rst_gasket_ctrl.sv
module rst_gasket_ctrl
  import rgc_pkg::*;
#(
  parameter int unsigned NBUS    = 2,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned DW      = 32,
  parameter int unsigned MIN_CYC = 2,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_rst_n,
  input  logic            cfg_busy,
  input  logic            ctl_we,
  input  logic [1:0]      ctl_wdata,
  output logic [1:0]      ctl_rdata,
  input  logic [NBUS-1:0] bus_req_fire,
  input  logic [NBUS-1:0] bus_rsp_fire,
  input  logic            host_acc_valid,
  output logic            host_acc_ready,
  input  logic [DW-1:0]   host_acc_data,
  output logic            mac_acc_valid,
  input  logic            mac_acc_ready,
  output logic [DW-1:0]   mac_acc_data,
  output logic            macro_rst,
  output logic            iso_en,
  output logic            macro_ready,
  output logic            bus_idle,
  output logic            pwr_down_req
);
  // Control register
  ctl_t ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RESET_VAL;
    else if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
  end

  assign ctl_rdata = ctl_q;
  assign iso_en    = ~ctl_q[CTL_CONN_B];

  // Asynchronous sources: assert at once, release through the synchronizer
  logic raw_async, sync_act;
  assign raw_async = ~rst_n | ~ext_rst_n | cfg_busy;

  rgc_rst_sync #(.STAGES(SYNC_N)) u_sync (
    .clk     (clk),
    .arst    (raw_async),
    .sync_act(sync_act)
  );

  // Synchronous sources combined, then stretched
  logic src_any, stretched;
  assign src_any = sync_act | ~ctl_q[CTL_RUN_B] | ~ctl_q[CTL_CONN_B];

  rgc_stretch #(.MIN_CYC(MIN_CYC)) u_stretch (
    .clk   (clk),
    .rst_n (rst_n),
    .src   (src_any),
    .active(stretched)
  );

  assign macro_rst   = raw_async | stretched;
  assign macro_ready = ~macro_rst;

  // Host-to-macro channel gated by readiness
  assign mac_acc_valid  = host_acc_valid & macro_ready;
  assign host_acc_ready = mac_acc_ready  & macro_ready;
  assign mac_acc_data   = host_acc_data;

  // Outstanding-transaction tracking, one counter per bus
  logic [NBUS-1:0] bus_zero;

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    rgc_txn_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (bus_req_fire[b]),
      .dec  (bus_rsp_fire[b]),
      .zero (bus_zero[b])
    );
  end

  assign bus_idle = &bus_zero;

  // Power-down request: set when quiesced, held until reconnect
  logic pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pd_q <= 1'b0;
    else if (!iso_en) pd_q <= 1'b0;
    else              pd_q <= pd_q | (macro_rst & bus_idle);
  end

  assign pwr_down_req = pd_q & iso_en;
endmodule

// File: rtl/rgc_chk.sv
module rgc_chk #(
  parameter int unsigned NBUS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ext_rst_n,
  input logic            ctl_we,
  input logic [1:0]      ctl_wdata,
  input logic [NBUS-1:0] bus_req_fire,
  input logic            macro_rst,
  input logic            iso_en,
  input logic            mac_acc_valid,
  input logic            bus_idle,
  input logic            pwr_down_req
);
  // R1
  pin_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rst_n |-> macro_rst);

  // R2
  min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(macro_rst) |=> macro_rst);

  // R3
  run_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[1]) |=> macro_rst);

  // R3
  iso_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (iso_en == !$past(ctl_wdata[0])));

  // R5
  gated_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_acc_valid |-> !macro_rst);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && (bus_req_fire == '0)) |=> bus_idle);

  // R7
  pd_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_req |-> (iso_en && macro_rst));
endmodule

bind rst_gasket_ctrl rgc_chk #(.NBUS(NBUS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ext_rst_n    (ext_rst_n),
  .ctl_we       (ctl_we),
  .ctl_wdata    (ctl_wdata),
  .bus_req_fire (bus_req_fire),
  .macro_rst    (macro_rst),
  .iso_en       (iso_en),
  .mac_acc_valid(mac_acc_valid),
  .bus_idle     (bus_idle),
  .pwr_down_req (pwr_down_req)
);

// File: tb/sim_rst_gasket_ctrl.sv
module sim_rst_gasket_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NBUS = 2;
  localparam int DW   = 32;

  logic clk = 0;
  logic rst_n = 0, ext_rst_n = 1, cfg_busy = 0;
  logic ctl_we = 0;
  logic [1:0] ctl_wdata = '0;
  logic [1:0] ctl_rdata;
  logic [NBUS-1:0] bus_req_fire = '0, bus_rsp_fire = '0;
  logic host_acc_valid = 0, host_acc_ready, mac_acc_valid, mac_acc_ready = 1;
  logic [DW-1:0] host_acc_data = '0, mac_acc_data;
  logic macro_rst, iso_en, macro_ready, bus_idle, pwr_down_req;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_gasket_ctrl #(.NBUS(NBUS), .DW(DW)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] v);
    ctl_we = 1; ctl_wdata = v; tick(); ctl_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // vector: {wdata[1:0], exp_rst, exp_iso}
  localparam logic [3:0] VEC [6] = '{
    4'b11_0_0, 4'b01_1_0, 4'b10_1_1, 4'b00_1_1, 4'b11_0_0, 4'b11_0_0
  };

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    // R4 reset state
    chk("R4 rdata", ctl_rdata, 2'b00);
    chk("R4 iso_en", iso_en, 1);
    chk("R4 macro_rst", macro_rst, 1);
    rst_n = 1;
    tick(); tick();
    chk("R4 held after release", macro_rst, 1);
    chk("R8 not ready", macro_ready, 0);

    // vector table (R3, R1)
    foreach (VEC[i]) begin
      wr(VEC[i][3:2]);
      tick();
      chk("R3 rdata", ctl_rdata, VEC[i][3:2]);
      chk("R1/R3 macro_rst", macro_rst, VEC[i][1]);
      chk("R3 iso_en", iso_en, VEC[i][0]);
    end

    // R9 rewrite while running
    wr(2'b11);
    chk("R9 no reset on rewrite", macro_rst, 0);
    tick();
    chk("R9 still running", macro_rst, 0);

    // R2 one-cycle run-bit pulse stretched to two cycles
    wr(2'b01);
    chk("R2 pulse cyc1", macro_rst, 1);
    wr(2'b11);
    chk("R2 pulse cyc2", macro_rst, 1);
    tick();
    chk("R2 pulse released", macro_rst, 0);

    // R1 R2 short glitch on external pin
    #2 ext_rst_n = 0;
    #1 chk("R1 async assert", macro_rst, 1);
    #1 ext_rst_n = 1;
    tick(); chk("R2 sync edge1", macro_rst, 1);
    tick(); chk("R2 sync edge2", macro_rst, 1);
    tick(); chk("R2 sync edge3 release", macro_rst, 0);
    chk("R8 ready", macro_ready, 1);

    // R1 configuration flag
    cfg_busy = 1; #1;
    chk("R1 cfg_busy", macro_rst, 1);
    tick(); tick(); cfg_busy = 0;
    tick(); tick(); tick();
    chk("R1 cfg released", macro_rst, 0);

    // R5 access gating
    host_acc_valid = 1; host_acc_data = 32'hA5A5_0001; #1;
    chk("R5 valid passes", mac_acc_valid, 1);
    chk("R5 ready passes", host_acc_ready, 1);
    chk("R5 data", mac_acc_data, 32'hA5A5_0001);
    wr(2'b01);
    chk("R5 valid blocked", mac_acc_valid, 0);
    chk("R5 ready blocked", host_acc_ready, 0);
    host_acc_valid = 0;
    wr(2'b11); tick();

    // R6 counters
    bus_req_fire = 2'b01; tick(); tick();
    bus_req_fire = 2'b00;
    chk("R6 busy", bus_idle, 0);
    bus_req_fire = 2'b01; bus_rsp_fire = 2'b01; tick();
    bus_req_fire = 0; bus_rsp_fire = 0;
    chk("R6 simultaneous", bus_idle, 0);
    bus_rsp_fire = 2'b01; tick();
    chk("R6 one left", bus_idle, 0);
    tick(); bus_rsp_fire = 0;
    chk("R6 idle", bus_idle, 1);
    bus_rsp_fire = 2'b10; tick(); bus_rsp_fire = 0;
    bus_req_fire = 2'b10; tick(); bus_req_fire = 0;
    chk("R6 underflow ignored", bus_idle, 0);

    // R7 power-down held off while busy
    wr(2'b00); tick(); tick();
    chk("R7 blocked by busy bus", pwr_down_req, 0);
    bus_rsp_fire = 2'b10; tick(); bus_rsp_fire = 0;
    chk("R7 idle now", bus_idle, 1);
    chk("R7 not yet", pwr_down_req, 0);
    tick();
    chk("R7 asserted", pwr_down_req, 1);
    bus_req_fire = 2'b01; tick(); bus_req_fire = 0;
    chk("R7 held", pwr_down_req, 1);
    wr(2'b01);
    chk("R7 cleared on reconnect", pwr_down_req, 0);
    bus_rsp_fire = 2'b01; tick(); bus_rsp_fire = 0;

    finish_run();
  end
endmodule